// File: doc/BRIEF.md
# Debug resume flag controller

This block keeps the single-bit resume flag that lets one instruction run past its own instruction breakpoint. A handler that wants to re-execute a faulting instruction sets the flag in its saved state image. The return path reloads the live flag from that image. The next instruction then passes its breakpoint check without a match being reported. After that check the flag clears, so the instruction that follows is checked normally again.

The block also works out the flag value that is saved when an event handler is entered. That value depends on the class of the event. For traps and hardware interrupts it also depends on whether the event came in the middle of a repeated string instruction, before its last iteration. The block matches no breakpoint addresses, builds no stack frame and decodes no instructions. Per-instruction strobes, the event class and the restore request arrive from the surrounding pipeline.

Top module: `rflag_ctrl`

## Requirements
- R1: After synchronous reset, `rf_live`, `bp_suppress`, `push_rf`, `ibp_fire` and `dbp_fire` are all 0.
- R2: `insn_start` arms a clear of the live flag. The clear takes effect at the edge of the first later or same cycle with `bp_check_done` or `retire`. The breakpoint check in that cycle still sees the flag value from before the clear.
- R3: In a cycle with `bp_check_done`, `ibp_fire` is 1 in the following cycle only if `ibp_match` was 1 and the live flag was 0. `ibp_fire` is 0 in every other cycle. `bp_suppress` follows the live flag.
- R4: In a cycle with `bp_check_done`, `dbp_fire` in the following cycle equals `dbp_match`, whatever the live flag is. Data and I/O breakpoints are not suppressed.
- R5: Event class codes are 0 fault, 1 trap, 2 hardware interrupt, 3 software interrupt and 4 instruction-breakpoint debug. A fault always saves 1.
- R6: A trap or a hardware interrupt saves 1 when `rep_string`=1 and `last_iter`=0. Otherwise it saves the live flag.
- R7: An instruction-breakpoint debug event saves the live flag. A software interrupt always saves 0.
- R8: The restore kind codes are 0 wide interrupt return, 1 task switch, 2 flag pop and 3 legacy interrupt return. Kinds 0 and 1 copy `restore_image` into the live flag. Kinds 2 and 3 leave the live flag unchanged.
- R9: A loading restore takes priority over a clear in the same cycle, and it cancels any armed clear. A flag restored as 1 suppresses the instruction-breakpoint report for exactly the next instruction.
- R10: `push_rf` is loaded on the edge where `evt_valid`=1 and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_start | input | 1 | Start of a new instruction |
| bp_check_done | input | 1 | Breakpoint check of the current instruction is being evaluated |
| retire | input | 1 | Current instruction retires |
| ibp_match | input | 1 | Instruction breakpoint matched in the check |
| dbp_match | input | 1 | Data or I/O breakpoint matched in the check |
| evt_valid | input | 1 | Handler entry strobe |
| evt_class | input | 3 | Event class code (R5) |
| rep_string | input | 1 | Event belongs to a repeated string instruction |
| last_iter | input | 1 | The iteration concerned is the last one |
| restore_valid | input | 1 | Return path is reloading the flags |
| restore_kind | input | 2 | Return path kind code (R8) |
| restore_image | input | 1 | Saved flag value carried by the return |
| rf_live | output | 1 | Live resume flag |
| bp_suppress | output | 1 | Instruction breakpoints currently ignored |
| push_rf | output | 1 | Flag value to save at handler entry |
| ibp_fire | output | 1 | Instruction breakpoint reported |
| dbp_fire | output | 1 | Data/I/O breakpoint reported |

## Verification
Every result is registered, so each one is due exactly one clock edge after its stimulus cycle. This applies to the flag after a restore or a clear, to both breakpoint reports after a check, and to the saved value after a handler entry. The bench drives inputs on the falling edge and samples on the next falling edge, which is half a cycle after the edge that produces the result. Chains such as the one-instruction suppression and the restore-versus-clear priority are checked one cycle at a time. Each check in these chains uses the flag value the bench predicted for the previous cycle.

// File: rtl/rflag_pkg.sv
package rflag_pkg;
  localparam int CLASS_W = 3;
  localparam int KIND_W  = 2;

  typedef enum logic [CLASS_W-1:0] {
    EV_FAULT = 3'd0,
    EV_TRAP  = 3'd1,
    EV_HWINT = 3'd2,
    EV_SWINT = 3'd3,
    EV_IBP   = 3'd4
  } evt_class_e;

  typedef enum logic [KIND_W-1:0] {
    RK_IRET_WIDE = 2'd0,
    RK_TASK_SW   = 2'd1,
    RK_POP       = 2'd2,
    RK_IRET_OLD  = 2'd3
  } rkind_e;
endpackage

// File: rtl/rflag_state.sv
module rflag_state
  import rflag_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   insn_start,
  input  logic   bp_check_done,
  input  logic   retire,
  input  logic   restore_valid,
  input  rkind_e restore_kind,
  input  logic   restore_image,
  output logic   rf_q
);
  logic pend_q;
  logic armed;
  logic load;

  assign armed = pend_q | insn_start;
  assign load  = restore_valid &&
                 (restore_kind == RK_IRET_WIDE || restore_kind == RK_TASK_SW);

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (load) begin
      rf_q   <= restore_image;
      pend_q <= 1'b0;
    end else if (armed && (bp_check_done || retire)) begin
      rf_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (insn_start) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rflag_bp_gate.sv
module rflag_bp_gate (
  input  logic clk,
  input  logic rst,
  input  logic bp_check_done,
  input  logic rf,
  input  logic ibp_match,
  input  logic dbp_match,
  output logic ibp_fire,
  output logic dbp_fire
);
  always_ff @(posedge clk) begin
    if (rst || !bp_check_done) begin
      ibp_fire <= 1'b0;
      dbp_fire <= 1'b0;
    end else begin
      ibp_fire <= ibp_match & ~rf;
      dbp_fire <= dbp_match;
    end
  end
endmodule

// File: rtl/rflag_push_sel.sv
module rflag_push_sel
  import rflag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       evt_valid,
  input  evt_class_e evt_class,
  input  logic       rep_string,
  input  logic       last_iter,
  input  logic       rf,
  output logic       push_rf
);
  logic mid_rep;
  logic nxt;

  assign mid_rep = rep_string & ~last_iter;

  always_comb begin
    case (evt_class)
      EV_FAULT:          nxt = 1'b1;
      EV_TRAP, EV_HWINT: nxt = mid_rep ? 1'b1 : rf;
      EV_SWINT:          nxt = 1'b0;
      default:           nxt = rf;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            push_rf <= 1'b0;
    else if (evt_valid) push_rf <= nxt;
  end
endmodule

// File: rtl/rflag_ctrl.sv
module rflag_ctrl
  import rflag_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               insn_start,
  input  logic               bp_check_done,
  input  logic               retire,
  input  logic               ibp_match,
  input  logic               dbp_match,
  input  logic               evt_valid,
  input  logic [CLASS_W-1:0] evt_class,
  input  logic               rep_string,
  input  logic               last_iter,
  input  logic               restore_valid,
  input  logic [KIND_W-1:0]  restore_kind,
  input  logic               restore_image,
  output logic               rf_live,
  output logic               bp_suppress,
  output logic               push_rf,
  output logic               ibp_fire,
  output logic               dbp_fire
);
  logic rf_q;

  rflag_state u_state (
    .clk           (clk),
    .rst           (rst),
    .insn_start    (insn_start),
    .bp_check_done (bp_check_done),
    .retire        (retire),
    .restore_valid (restore_valid),
    .restore_kind  (rkind_e'(restore_kind)),
    .restore_image (restore_image),
    .rf_q          (rf_q)
  );

  rflag_bp_gate u_gate (
    .clk           (clk),
    .rst           (rst),
    .bp_check_done (bp_check_done),
    .rf            (rf_q),
    .ibp_match     (ibp_match),
    .dbp_match     (dbp_match),
    .ibp_fire      (ibp_fire),
    .dbp_fire      (dbp_fire)
  );

  rflag_push_sel u_push (
    .clk        (clk),
    .rst        (rst),
    .evt_valid  (evt_valid),
    .evt_class  (evt_class_e'(evt_class)),
    .rep_string (rep_string),
    .last_iter  (last_iter),
    .rf         (rf_q),
    .push_rf    (push_rf)
  );

  assign rf_live     = rf_q;
  assign bp_suppress = rf_q;
endmodule

// File: rtl/rflag_chk.sv
module rflag_chk (
  input logic       clk,
  input logic       rst,
  input logic       insn_start,
  input logic       bp_check_done,
  input logic       retire,
  input logic       ibp_match,
  input logic       dbp_match,
  input logic       evt_valid,
  input logic [2:0] evt_class,
  input logic       rep_string,
  input logic       last_iter,
  input logic       restore_valid,
  input logic [1:0] restore_kind,
  input logic       restore_image,
  input logic       rf_live,
  input logic       push_rf,
  input logic       ibp_fire,
  input logic       dbp_fire
);
  // R3
  suppress_ibp_chk: assert property (@(posedge clk) disable iff (rst)
    (bp_check_done && rf_live) |=> !ibp_fire);

  // R4
  dbp_pass_chk: assert property (@(posedge clk) disable iff (rst)
    bp_check_done |=> (dbp_fire == $past(dbp_match)));

  // R5
  fault_push_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_class == 3'd0) |=> push_rf);

  // R7
  swint_push_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_class == 3'd3) |=> !push_rf);

  // R8
  restore_load_chk: assert property (@(posedge clk) disable iff (rst)
    (restore_valid && restore_kind[1] == 1'b0) |=> (rf_live == $past(restore_image)));

  // R8
  restore_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (restore_valid && restore_kind[1] && !bp_check_done && !retire) |=> $stable(rf_live));

  // R10
  push_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |=> $stable(push_rf));

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (insn_start && bp_check_done && !restore_valid) |=> !rf_live);
endmodule

bind rflag_ctrl rflag_chk u_chk (
  .clk(clk), .rst(rst), .insn_start(insn_start), .bp_check_done(bp_check_done),
  .retire(retire), .ibp_match(ibp_match), .dbp_match(dbp_match),
  .evt_valid(evt_valid), .evt_class(evt_class), .rep_string(rep_string),
  .last_iter(last_iter), .restore_valid(restore_valid), .restore_kind(restore_kind),
  .restore_image(restore_image), .rf_live(rf_live), .push_rf(push_rf),
  .ibp_fire(ibp_fire), .dbp_fire(dbp_fire)
);

// File: tb/sim_rflag_ctrl.sv
module sim_rflag_ctrl;
  logic clk = 1'b0;
  logic rst;
  logic insn_start, bp_check_done, retire, ibp_match, dbp_match;
  logic evt_valid, rep_string, last_iter, restore_valid, restore_image;
  logic [2:0] evt_class;
  logic [1:0] restore_kind;
  logic rf_live, bp_suppress, push_rf, ibp_fire, dbp_fire;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rflag_ctrl u0 (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle();
    insn_start = 0; bp_check_done = 0; retire = 0; ibp_match = 0; dbp_match = 0;
    evt_valid = 0; evt_class = 0; rep_string = 0; last_iter = 0;
    restore_valid = 0; restore_kind = 0; restore_image = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic do_restore(input logic [1:0] kind, input logic img);
    restore_valid = 1; restore_kind = kind; restore_image = img;
    tick();
  endtask

  task automatic do_insn(input logic ib, input logic db);
    insn_start = 1; bp_check_done = 1; ibp_match = ib; dbp_match = db;
    tick();
  endtask

  task automatic do_evt(input logic [2:0] cls, input logic rep, input logic last);
    evt_valid = 1; evt_class = cls; rep_string = rep; last_iter = last;
    tick();
  endtask

  task automatic t_reset();
    rst = 1; idle();
    tick(); tick();
    rst = 0;
    chk("R1 rf_live", rf_live, 0);
    chk("R1 bp_suppress", bp_suppress, 0);
    chk("R1 push_rf", push_rf, 0);
    chk("R1 ibp_fire", ibp_fire, 0);
    chk("R1 dbp_fire", dbp_fire, 0);
  endtask

  task automatic t_one_insn_suppress();
    do_restore(2'd0, 1);
    chk("R8 wide return loads 1", rf_live, 1);
    chk("R3 bp_suppress follows flag", bp_suppress, 1);
    do_insn(1, 1);
    chk("R3 ibp suppressed", ibp_fire, 0);
    chk("R4 dbp still reported", dbp_fire, 1);
    chk("R2 flag cleared after check", rf_live, 0);
    do_insn(1, 0);
    chk("R9 next insn breakpoint reported", ibp_fire, 1);
    chk("R4 dbp follows match 0", dbp_fire, 0);
    tick();
    chk("R3 ibp_fire is a pulse", ibp_fire, 0);
  endtask

  task automatic t_ignored_restores();
    do_restore(2'd2, 1);
    chk("R8 flag pop ignored", rf_live, 0);
    do_restore(2'd3, 1);
    chk("R8 legacy return ignored", rf_live, 0);
    do_restore(2'd1, 1);
    chk("R8 task switch loads 1", rf_live, 1);
    do_restore(2'd2, 0);
    chk("R8 flag pop keeps 1", rf_live, 1);
    do_restore(2'd1, 0);
    chk("R8 task switch loads 0", rf_live, 0);
  endtask

  task automatic t_push();
    do_evt(3'd0, 0, 0);
    chk("R5 fault saves 1 with flag 0", push_rf, 1);
    do_evt(3'd4, 0, 0);
    chk("R7 ibp debug saves flag 0", push_rf, 0);
    tick();
    chk("R10 push holds", push_rf, 0);
    do_evt(3'd2, 1, 0);
    chk("R6 hw int mid string saves 1", push_rf, 1);
    do_evt(3'd2, 1, 1);
    chk("R6 hw int after last iteration saves flag 0", push_rf, 0);
    do_evt(3'd1, 1, 0);
    chk("R6 trap mid string saves 1", push_rf, 1);
    tick();
    chk("R10 push holds 1", push_rf, 1);
    do_evt(3'd1, 0, 0);
    chk("R6 trap after insn saves flag 0", push_rf, 0);
    do_restore(2'd0, 1);
    do_evt(3'd4, 0, 0);
    chk("R7 ibp debug saves flag 1", push_rf, 1);
    do_evt(3'd3, 0, 0);
    chk("R7 soft int saves 0", push_rf, 0);
    do_evt(3'd2, 0, 0);
    chk("R6 hw int between insns saves flag 1", push_rf, 1);
    do_restore(2'd0, 0);
  endtask

  task automatic t_priority();
    insn_start = 1; bp_check_done = 1; ibp_match = 1;
    restore_valid = 1; restore_kind = 2'd0; restore_image = 1;
    tick();
    chk("R9 restore beats clear", rf_live, 1);
    chk("R3 check saw flag 0 before restore", ibp_fire, 1);
    insn_start = 1; tick();
    chk("R2 armed clear waits for check", rf_live, 1);
    bp_check_done = 1; ibp_match = 1; tick();
    chk("R9 following insn suppressed", ibp_fire, 0);
    chk("R2 cleared at check", rf_live, 0);
    do_restore(2'd1, 1);
    insn_start = 1; tick();
    retire = 1; tick();
    chk("R2 retire clears without check", rf_live, 0);
  endtask

  initial begin
    t_reset();
    t_one_insn_suppress();
    t_ignored_restores();
    t_push();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule